// File: doc/BRIEF.md
# Unaligned Word Byte-Lane Merger

This block holds the byte-lane steering for a pair of partial-word instructions that together move a 32-bit word sitting at any byte address. A "left" access handles the part of the unaligned word that lies in the lower-addressed aligned word. A "right" access handles the part in the higher-addressed aligned word. Issued back to back, the two accesses assemble or scatter the whole unaligned word.

For a load, the block takes the aligned memory word, the two low address bits, the endian mode and the current destination register value. It returns the register value with only the selected byte lanes replaced. For a store, it returns lane-aligned write data and a 4-bit byte-enable mask. The block is purely combinational.

Top module: `unaligned_merge`

## Requirements
- R1: Operation encoding on `opKind`: 0 load-left, 1 load-right, 2 store-left, 3 store-right. In big-endian mode, memory byte offset k sits at bits [31-8k:24-8k], and lane i of any word is bits [8i+7:8i]. A load-left at offset a puts memory bytes a..3 into register bytes of descending significance, starting at the most significant byte. The low a register bytes keep their value.
- R2: In big-endian mode, a load-right at offset a puts memory byte a in the least significant register byte, byte a-1 in the next, and so on down to byte 0. The upper 3-a register bytes keep their value.
- R3: A load-left at address 101 followed by a load-right at 104 (big-endian) leaves the register holding bytes 101, 102, 103, 104, from most to least significant.
- R4: A load-left at address 203 writes only the most significant register byte. A following load-right at 206 fills the other three bytes with bytes 204, 205, 206.
- R5: In little-endian mode, memory byte offset k sits at bits [8k+7:8k]. Selection then behaves as in big-endian mode with the two offset bits complemented. Load-left at offset a fills from the most significant register byte downward with bytes a, a-1, .., 0. Load-right fills from the least significant byte upward with bytes a, a+1, .., 3.
- R6: Store-left is the inverse of load-left. Each memory byte that the matching load-left would read receives the register byte that load would have written from it, and exactly those byte lanes are enabled.
- R7: Store-right is the inverse of load-right in the same sense, with exactly the matching lanes enabled.
- R8: During a store, disabled lanes of `storeData` are zero. During a load, `storeMask` and `storeData` are all zero.
- R9: During a store, `loadResult` equals `regVal`.
- R10: A load-left at effective offset 0 (big-endian offset 0, little-endian offset 3) and a load-right at effective offset 3 each return the whole memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| memWord | input | 32 | Aligned memory word containing the addressed byte |
| regVal | input | 32 | Current register value (load target, store source) |
| addrLow | input | 2 | Low two bits of the byte address |
| opKind | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| bigEndian | input | 1 | 1 big-endian, 0 little-endian |
| loadResult | output | 32 | Merged register value |
| storeData | output | 32 | Lane-aligned store data |
| storeMask | output | 4 | Byte enables, bit i for bits [8i+7:8i] |

## Verification
Every operation, offset and endian mode is applied with memory and register words whose bytes are all distinct. A lane taken from the wrong byte, or taken from the wrong source, is therefore visible. All-zero and all-ones words are also applied against opposite register contents, which separates "lane replaced" from "lane kept" independently of the shift amount. The two two-instruction sequences from the requirements are run as written, checking that left and right halves meet without overlap or gap.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'd0,
    OP_LOAD_RIGHT  = 2'd1,
    OP_STORE_LEFT  = 2'd2,
    OP_STORE_RIGHT = 2'd3
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic isStore;    // source is register, drive store outputs
    logic shiftLeft;  // byte shift direction toward higher lanes
  } laneStrobe_t;

endpackage

// File: rtl/umerge_ctrl.sv
module umerge_ctrl #(
  parameter int LANES = 4,
  localparam int OFFW = $clog2(LANES)
) (
  input  logic [1:0]                  opKind,
  input  logic [OFFW-1:0]             addrLow,
  input  logic                        bigEndian,
  output umerge_pkg::laneStrobe_t     strobe,
  output logic [OFFW-1:0]             shiftAmt,
  output logic [LANES-1:0]            laneMask
);
  import umerge_pkg::*;

  localparam logic [OFFW-1:0] LAST = OFFW'(LANES - 1);

  logic [OFFW-1:0]  effOff;
  logic [OFFW-1:0]  compOff;
  logic [LANES-1:0] allOnes;

  // little-endian selection is big-endian selection on the complemented offset
  assign effOff  = addrLow ^ {OFFW{~bigEndian}};
  assign compOff = LAST - effOff;
  assign allOnes = '1;

  always_comb begin
    strobe.isStore   = opKind[1];
    strobe.shiftLeft = 1'b0;
    shiftAmt         = '0;
    laneMask         = '0;
    unique case (opKind_e'(opKind))
      OP_LOAD_LEFT: begin
        strobe.shiftLeft = 1'b1;
        shiftAmt         = effOff;
        laneMask         = allOnes << effOff;
      end
      OP_LOAD_RIGHT: begin
        strobe.shiftLeft = 1'b0;
        shiftAmt         = compOff;
        laneMask         = allOnes >> compOff;
      end
      OP_STORE_LEFT: begin
        strobe.shiftLeft = 1'b0;
        shiftAmt         = effOff;
        laneMask         = allOnes >> effOff;
      end
      OP_STORE_RIGHT: begin
        strobe.shiftLeft = 1'b1;
        shiftAmt         = compOff;
        laneMask         = allOnes << compOff;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/umerge_dp.sv
module umerge_dp #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFFW  = $clog2(LANES),
  localparam int WORDW = LANES * BYTE_W
) (
  input  logic [WORDW-1:0]            memWord,
  input  logic [WORDW-1:0]            regVal,
  input  umerge_pkg::laneStrobe_t     strobe,
  input  logic [OFFW-1:0]             shiftAmt,
  input  logic [LANES-1:0]            laneMask,
  output logic [WORDW-1:0]            loadResult,
  output logic [WORDW-1:0]            storeData,
  output logic [LANES-1:0]            storeMask
);

  logic [WORDW-1:0] srcWord;
  logic [WORDW-1:0] shifted;

  assign srcWord = strobe.isStore ? regVal : memWord;

  // byte barrel shifter, vacated lanes fill with zero
  always_comb begin
    int srcLane;
    shifted = '0;
    for (int i = 0; i < LANES; i++) begin
      srcLane = strobe.shiftLeft ? (i - int'(shiftAmt)) : (i + int'(shiftAmt));
      if (srcLane >= 0 && srcLane < LANES)
        shifted[i*BYTE_W +: BYTE_W] = srcWord[srcLane*BYTE_W +: BYTE_W];
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      assign loadResult[g*BYTE_W +: BYTE_W] =
        (!strobe.isStore && laneMask[g]) ? shifted[g*BYTE_W +: BYTE_W]
                                         : regVal[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign storeData = strobe.isStore ? shifted  : '0;
  assign storeMask = strobe.isStore ? laneMask : '0;

endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFFW  = $clog2(LANES),
  localparam int WORDW = LANES * BYTE_W
) (
  input  logic [WORDW-1:0] memWord,
  input  logic [WORDW-1:0] regVal,
  input  logic [OFFW-1:0]  addrLow,
  input  logic [1:0]       opKind,
  input  logic             bigEndian,
  output logic [WORDW-1:0] loadResult,
  output logic [WORDW-1:0] storeData,
  output logic [LANES-1:0] storeMask
);
  import umerge_pkg::*;

  laneStrobe_t      strobe;
  logic [OFFW-1:0]  shiftAmt;
  logic [LANES-1:0] laneMask;

  umerge_ctrl #(.LANES(LANES)) uCtrl (
    .opKind   (opKind),
    .addrLow  (addrLow),
    .bigEndian(bigEndian),
    .strobe   (strobe),
    .shiftAmt (shiftAmt),
    .laneMask (laneMask)
  );

  umerge_dp #(.LANES(LANES), .BYTE_W(BYTE_W)) uDp (
    .memWord   (memWord),
    .regVal    (regVal),
    .strobe    (strobe),
    .shiftAmt  (shiftAmt),
    .laneMask  (laneMask),
    .loadResult(loadResult),
    .storeData (storeData),
    .storeMask (storeMask)
  );

endmodule

// File: rtl/umerge_chk.sv
module umerge_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFFW  = $clog2(LANES),
  localparam int WORDW = LANES * BYTE_W
) (
  input logic [WORDW-1:0] memWord,
  input logic [WORDW-1:0] regVal,
  input logic [OFFW-1:0]  addrLow,
  input logic [1:0]       opKind,
  input logic             bigEndian,
  input logic [WORDW-1:0] loadResult,
  input logic [WORDW-1:0] storeData,
  input logic [LANES-1:0] storeMask
);

  localparam logic [OFFW-1:0] LAST = OFFW'(LANES - 1);

  logic [WORDW-1:0] maskBits;
  logic             known;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      maskBits[i*BYTE_W +: BYTE_W] = {BYTE_W{storeMask[i]}};
  end

  assign known = !$isunknown({memWord, regVal, addrLow, opKind, bigEndian,
                              loadResult, storeData, storeMask});

  always_comb begin
    if (known) begin
      // R8
      load_no_store_chk: assert (opKind[1] || (storeMask == '0 && storeData == '0))
        else $error("store outputs active during a load");
      // R8
      dead_lane_zero_chk: assert (!opKind[1] || (storeData & ~maskBits) == '0)
        else $error("disabled store lane carries data");
      // R9
      store_keeps_reg_chk: assert (!opKind[1] || loadResult == regVal)
        else $error("store changed the load result");
      // R10
      whole_left_chk: assert (!(opKind == 2'd0 && addrLow == (bigEndian ? '0 : LAST))
                              || loadResult == memWord)
        else $error("full load-left did not return the word");
      // R10
      whole_right_chk: assert (!(opKind == 2'd1 && addrLow == (bigEndian ? LAST : '0))
                               || loadResult == memWord)
        else $error("full load-right did not return the word");
      // R6
      store_some_lane_chk: assert (!opKind[1] || storeMask != '0)
        else $error("store enabled no lane");
    end
  end

endmodule

bind unaligned_merge umerge_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) uChk (
  .memWord   (memWord),
  .regVal    (regVal),
  .addrLow   (addrLow),
  .opKind    (opKind),
  .bigEndian (bigEndian),
  .loadResult(loadResult),
  .storeData (storeData),
  .storeMask (storeMask)
);

// File: tb/unaligned_merge_test.sv
module unaligned_merge_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic [31:0] memWord = '0;
  logic [31:0] regVal = '0;
  logic [1:0]  addrLow = '0;
  logic [1:0]  opKind = '0;
  logic        bigEndian = 1'b1;
  logic [31:0] loadResult;
  logic [31:0] storeData;
  logic [3:0]  storeMask;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  bit finished   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unaligned_merge uut (
    .memWord   (memWord),
    .regVal    (regVal),
    .addrLow   (addrLow),
    .opKind    (opKind),
    .bigEndian (bigEndian),
    .loadResult(loadResult),
    .storeData (storeData),
    .storeMask (storeMask)
  );

  // memory byte at offset k -> bit lane
  function automatic int laneOf(int k, bit be);
    return be ? (3 - k) : k;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference: load result by bytes
  function automatic logic [31:0] refLoad(logic [31:0] m, logic [31:0] r,
                                          int a, bit right, bit be);
    logic [31:0] res = r;
    for (int j = 0; j < 4; j++) begin
      int sig;
      int k;
      if (!right) begin sig = 3 - j; k = be ? a + j : a - j; end
      else        begin sig = j;     k = be ? a - j : a + j; end
      if (k >= 0 && k <= 3)
        res[sig*8 +: 8] = m[laneOf(k, be)*8 +: 8];
    end
    return res;
  endfunction

  // reference: store data and mask by bytes
  function automatic logic [35:0] refStore(logic [31:0] r, int a, bit right, bit be);
    logic [31:0] d = '0;
    logic [3:0]  en = '0;
    for (int j = 0; j < 4; j++) begin
      int sig;
      int k;
      if (!right) begin sig = 3 - j; k = be ? a + j : a - j; end
      else        begin sig = j;     k = be ? a - j : a + j; end
      if (k >= 0 && k <= 3) begin
        d[laneOf(k, be)*8 +: 8] = r[sig*8 +: 8];
        en[laneOf(k, be)] = 1'b1;
      end
    end
    return {en, d};
  endfunction

  task automatic apply(logic [31:0] m, logic [31:0] r, int a, int op, bit be);
    @(negedge clk);
    memWord = m; regVal = r; addrLow = 2'(a); opKind = 2'(op); bigEndian = be;
    #(CLK_PERIOD/4);
  endtask

  // word at aligned base: bytes base..base+3 carry their address low byte
  function automatic logic [31:0] wordAt(int base, bit be);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[laneOf(k, be)*8 +: 8] = 8'(base + k);
    return w;
  endfunction

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > WATCHDOG_CYCLES && !finished) begin
      finished = 1'b1;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    logic [31:0] r;
    logic [35:0] st;
    repeat (2) @(posedge clk);

    // exhaustive sweep
    for (int be = 0; be < 2; be++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < 4; a++)
          for (int p = 0; p < 6; p++) begin
            string tag;
            case (p)
              4: begin m = 32'h0000_0000; r = 32'hFFFF_FFFF; end
              5: begin m = 32'hFFFF_FFFF; r = 32'h0000_0000; end
              default: begin
                m = {8'(8'hA1 + p), 8'(8'hB2 + p), 8'(8'hC3 + p), 8'(8'hD4 + p)};
                r = {8'(8'h15 + p), 8'(8'h26 + p), 8'(8'h37 + p), 8'(8'h48 + p)};
              end
            endcase
            apply(m, r, a, op, bit'(be));
            if (op < 2) begin
              tag = (be == 0) ? "R5 load" : (op == 0 ? "R1 load-left" : "R2 load-right");
              if ((op == 0 && a == (be ? 0 : 3)) || (op == 1 && a == (be ? 3 : 0)))
                tag = {tag, " R10 whole word"};
              check(tag, loadResult, refLoad(m, r, a, op[0], bit'(be)));
              check("R8 load store-mask", {28'd0, storeMask}, 32'd0);
              check("R8 load store-data", storeData, 32'd0);
            end else begin
              st = refStore(r, a, op[0], bit'(be));
              tag = (op == 2) ? "R6 store-left" : "R7 store-right";
              if (be == 0) tag = {tag, " R5"};
              check({tag, " data R8"}, storeData, st[31:0]);
              check({tag, " mask"}, {28'd0, storeMask}, {28'd0, st[35:32]});
              check("R9 store keeps reg", loadResult, r);
            end
          end

    // R3: left at 101 then right at 104, big-endian
    apply(wordAt(100, 1'b1), 32'h5555_5555, 1, 0, 1'b1);
    r = loadResult;
    apply(wordAt(104, 1'b1), r, 0, 1, 1'b1);
    check("R3 left101 right104", loadResult, 32'h6566_6768);

    // R4: left at 203 touches only the top byte, then right at 206
    apply(wordAt(200, 1'b1), 32'h1122_3344, 3, 0, 1'b1);
    check("R4 left203 only msb", loadResult, 32'hCB22_3344);
    r = loadResult;
    apply(wordAt(204, 1'b1), r, 2, 1, 1'b1);
    check("R4 right206", loadResult, 32'hCBCC_CDCE);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

endmodule